// File: doc/BRIEF.md
# Device-Side Channel Tag Responder

This block sits at the device end of a processor I/O channel and answers the processor's outbound gate tags with inbound return tags. For a direct program control (DPC) sequence it takes a command from the upper byte of the address bus when the address gate arrives. It then raises the address gate return and presents a condition code and, for a read, the data bus.

For a cycle-steal or interrupt service sequence the device must first have captured a poll. Poll arbitration is outside the block and shows up only as a one-cycle `poll_capture_i` input. After a capture, only a fresh rising edge of the service gate starts a sequence. The block then raises the service gate return and drives the data bus and condition code. On a cycle steal it also drives the address bus. Every return tag is held until its gate drops. The block then releases the return and zeroes every bus it was driving. Completing a service sequence uses up the poll capture.

States: `ST_IDLE`, `ST_DPC_ACTIVE`, `ST_POLL_CAPTURED`, `ST_SERVICE_ACTIVE`. The transitions are:
- IDLE→DPC_ACTIVE when the address gate is high. This has priority over a poll capture in the same cycle.
- IDLE→POLL_CAPTURED on a poll capture.
- DPC_ACTIVE→IDLE when the address gate is low.
- POLL_CAPTURED→SERVICE_ACTIVE on a service gate rising edge.
- SERVICE_ACTIVE→IDLE when the service gate is low.

Top module: `io_tag_responder`

## Requirements
- R1: After reset, both return tags, the command strobe, all bus outputs and both bus enables are 0.
- R2: In IDLE, a high address gate makes `addr_gate_ret_o` rise one cycle later. In that same cycle `cmd_o` holds `addr_bus_i[15:8]` and `cmd_strobe_o` is high for exactly one cycle.
- R3: A return tag stays high while its gate is high. It falls one cycle after the gate goes low, and in that same cycle `cc_in_o`, `data_bus_o`, `addr_bus_o` and both enables return to 0.
- R4: During a DPC read (`is_read_i`=1 at start), the data bus carries `rd_data_i` with `data_bus_oe_o`=1. During a DPC write, the data bus is 0 and its enable is 0.
- R5: On DPC and interrupt sequences, the condition code is laid out as `cc_in_o[0]`=even, `cc_in_o[1]`=carry and `cc_in_o[2]`=overflow.
- R6: A poll capture in IDLE arms the device. A later service gate rising edge makes `svc_gate_ret_o` rise one cycle after that edge.
- R7: A service gate that is already high when the poll is captured starts nothing. A sequence starts only after the gate falls and rises again.
- R8: A service gate edge with no captured poll is ignored, and `svc_gate_ret_o` stays 0.
- R9: On a cycle steal (`is_cycle_steal_i`=1 at start), `addr_bus_o` carries `cs_addr_i` with `addr_bus_oe_o`=1, `cc_in_o` carries `cs_cc_i`, and the data bus is driven. On an interrupt sequence, the address bus is 0 with its enable at 0, and the data bus is driven.
- R10: Each poll capture permits exactly one service sequence. A further service gate edge after completion is ignored.
- R11: Gates and captures that arrive in the wrong state are ignored. This covers an address gate while a poll is captured and a poll capture during DPC.
- R12: Command, data, address, condition code and read/kind selections are latched at sequence start. Later input changes do not alter the outputs during that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_gate_i | input | 1 | Outbound address gate tag |
| svc_gate_i | input | 1 | Outbound service gate tag |
| poll_capture_i | input | 1 | One-cycle pulse: this device captured a poll |
| addr_bus_i | input | 16 | Outbound address bus; command in bits 15:8 |
| is_read_i | input | 1 | DPC command is a read |
| is_cycle_steal_i | input | 1 | Pending service is a cycle steal (else interrupt) |
| ind_even_i | input | 1 | Even indicator to report |
| ind_carry_i | input | 1 | Carry indicator to report |
| ind_overflow_i | input | 1 | Overflow indicator to report |
| cs_cc_i | input | 3 | Condition code for cycle steal |
| rd_data_i | input | 16 | Data the device presents |
| cs_addr_i | input | 16 | Storage address for cycle steal |
| addr_gate_ret_o | output | 1 | Inbound address gate return |
| svc_gate_ret_o | output | 1 | Inbound service gate return |
| cc_in_o | output | 3 | Inbound condition code |
| data_bus_o | output | 16 | Inbound data bus value |
| data_bus_oe_o | output | 1 | Data bus drive enable |
| addr_bus_o | output | 16 | Inbound address bus value (cycle steal) |
| addr_bus_oe_o | output | 1 | Address bus drive enable |
| cmd_o | output | 8 | Latched command |
| cmd_strobe_o | output | 1 | One-cycle pulse on command acceptance |

## Verification
All results are due one clock after the stimulus. A gate, or a gate's fall, sampled at one rising edge shows up on the returns and buses right after that edge. The exception is the command strobe, which falls after one more edge. The bench drives inputs on falling edges and checks at the next falling edge, half a cycle after the register update. Tests that expect something to be ignored hold the stimulus for two or more cycles and watch the return tags and bus enables throughout. The latching checks change the inputs mid-sequence and read the outputs one cycle later.

// File: rtl/io_tag_pkg.sv
package io_tag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE           = 2'd0,
        ST_DPC_ACTIVE     = 2'd1,
        ST_POLL_CAPTURED  = 2'd2,
        ST_SERVICE_ACTIVE = 2'd3
    } tag_state_e;

    typedef enum logic [1:0] {
        SEQ_NONE        = 2'd0,
        SEQ_DPC         = 2'd1,
        SEQ_INTERRUPT   = 2'd2,
        SEQ_CYCLE_STEAL = 2'd3
    } seq_kind_e;

endpackage

// File: rtl/tag_edge_detect.sv
module tag_edge_detect #(
    parameter int NUM_TAGS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAGS-1:0] tag_i,
    output logic [NUM_TAGS-1:0] rise_o
);

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_tag
        logic level_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                level_q <= 1'b0;
            end else begin
                level_q <= tag_i[g];
            end
        end

        assign rise_o[g] = tag_i[g] & ~level_q;
    end

endmodule

// File: rtl/tag_fsm.sv
module tag_fsm
    import io_tag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_gate_i,
    input  logic       svc_gate_i,
    input  logic       svc_rise_i,
    input  logic       poll_capture_i,
    input  logic       is_cycle_steal_i,
    output tag_state_e state_o,
    output logic       start_o,
    output seq_kind_e  start_kind_o,
    output logic       addr_ret_o,
    output logic       svc_ret_o,
    output logic       active_o,
    output logic       strobe_o
);

    tag_state_e state_q;
    tag_state_e state_d;
    logic       strobe_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            strobe_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            strobe_q <= (state_q == ST_IDLE) && (state_d == ST_DPC_ACTIVE);
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_gate_i) begin
                    state_d = ST_DPC_ACTIVE;
                end else if (poll_capture_i) begin
                    state_d = ST_POLL_CAPTURED;
                end
            end
            ST_DPC_ACTIVE: begin
                if (!addr_gate_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_POLL_CAPTURED: begin
                if (svc_rise_i) begin
                    state_d = ST_SERVICE_ACTIVE;
                end
            end
            ST_SERVICE_ACTIVE: begin
                if (!svc_gate_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        addr_ret_o   = 1'b0;
        svc_ret_o    = 1'b0;
        start_o      = 1'b0;
        start_kind_o = SEQ_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (state_d == ST_DPC_ACTIVE) begin
                    start_o      = 1'b1;
                    start_kind_o = SEQ_DPC;
                end
            end
            ST_DPC_ACTIVE: begin
                addr_ret_o = 1'b1;
            end
            ST_POLL_CAPTURED: begin
                if (state_d == ST_SERVICE_ACTIVE) begin
                    start_o      = 1'b1;
                    start_kind_o = is_cycle_steal_i ? SEQ_CYCLE_STEAL : SEQ_INTERRUPT;
                end
            end
            ST_SERVICE_ACTIVE: begin
                svc_ret_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign active_o = addr_ret_o | svc_ret_o;
    assign strobe_o = strobe_q;
    assign state_o  = state_q;

endmodule

// File: rtl/cc_encoder.sv
module cc_encoder
    import io_tag_pkg::*;
#(
    parameter int CC_W = 3
) (
    input  seq_kind_e         kind_i,
    input  logic              even_i,
    input  logic              carry_i,
    input  logic              overflow_i,
    input  logic [CC_W-1:0]   cs_cc_i,
    output logic [CC_W-1:0]   cc_o
);

    localparam int IND_BITS = 3;

    logic [IND_BITS-1:0] ind_code;
    assign ind_code = {overflow_i, carry_i, even_i};

    always_comb begin
        cc_o = '0;
        unique case (kind_i)
            SEQ_DPC, SEQ_INTERRUPT: cc_o[IND_BITS-1:0] = ind_code;
            SEQ_CYCLE_STEAL:        cc_o = cs_cc_i;
            default:                cc_o = '0;
        endcase
    end

endmodule

// File: rtl/bus_capture.sv
module bus_capture
    import io_tag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CC_W   = 3,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  seq_kind_e         kind_i,
    input  logic              is_read_i,
    input  logic              active_i,
    input  logic [ADDR_W-1:0] addr_bus_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] cs_addr_i,
    input  logic [CC_W-1:0]   cc_i,
    output logic [CC_W-1:0]   cc_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe_o,
    output logic [CMD_W-1:0]  cmd_o
);

    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CC_W-1:0]   cc_q;
    logic [CMD_W-1:0]  cmd_q;
    logic              data_en_q;
    logic              addr_en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= '0;
            addr_q    <= '0;
            cc_q      <= '0;
            cmd_q     <= '0;
            data_en_q <= 1'b0;
            addr_en_q <= 1'b0;
        end else if (load_i) begin
            data_q    <= data_i;
            addr_q    <= cs_addr_i;
            cc_q      <= cc_i;
            data_en_q <= (kind_i != SEQ_DPC) || is_read_i;
            addr_en_q <= (kind_i == SEQ_CYCLE_STEAL);
            if (kind_i == SEQ_DPC) begin
                cmd_q <= addr_bus_i[ADDR_W-1 -: CMD_W];
            end
        end
    end

    always_comb begin
        cc_o      = active_i ? cc_q : '0;
        data_oe_o = active_i & data_en_q;
        addr_oe_o = active_i & addr_en_q;
        data_o    = data_oe_o ? data_q : '0;
        addr_o    = addr_oe_o ? addr_q : '0;
    end

    assign cmd_o = cmd_q;

endmodule

// File: rtl/io_tag_responder.sv
module io_tag_responder
    import io_tag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CC_W   = 3,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_gate_i,
    input  logic              svc_gate_i,
    input  logic              poll_capture_i,
    input  logic [ADDR_W-1:0] addr_bus_i,
    input  logic              is_read_i,
    input  logic              is_cycle_steal_i,
    input  logic              ind_even_i,
    input  logic              ind_carry_i,
    input  logic              ind_overflow_i,
    input  logic [CC_W-1:0]   cs_cc_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [ADDR_W-1:0] cs_addr_i,
    output logic              addr_gate_ret_o,
    output logic              svc_gate_ret_o,
    output logic [CC_W-1:0]   cc_in_o,
    output logic [DATA_W-1:0] data_bus_o,
    output logic              data_bus_oe_o,
    output logic [ADDR_W-1:0] addr_bus_o,
    output logic              addr_bus_oe_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              cmd_strobe_o
);

    localparam int NUM_TAGS = 2;
    localparam int SVC_IDX  = 1;

    logic [NUM_TAGS-1:0] gate_rise;
    tag_state_e          state;
    logic                start;
    seq_kind_e           start_kind;
    logic                active;
    logic [CC_W-1:0]     cc_start;

    tag_edge_detect #(.NUM_TAGS(NUM_TAGS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tag_i  ({svc_gate_i, addr_gate_i}),
        .rise_o (gate_rise)
    );

    tag_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .addr_gate_i      (addr_gate_i),
        .svc_gate_i       (svc_gate_i),
        .svc_rise_i       (gate_rise[SVC_IDX]),
        .poll_capture_i   (poll_capture_i),
        .is_cycle_steal_i (is_cycle_steal_i),
        .state_o          (state),
        .start_o          (start),
        .start_kind_o     (start_kind),
        .addr_ret_o       (addr_gate_ret_o),
        .svc_ret_o        (svc_gate_ret_o),
        .active_o         (active),
        .strobe_o         (cmd_strobe_o)
    );

    cc_encoder #(.CC_W(CC_W)) u_cc (
        .kind_i     (start_kind),
        .even_i     (ind_even_i),
        .carry_i    (ind_carry_i),
        .overflow_i (ind_overflow_i),
        .cs_cc_i    (cs_cc_i),
        .cc_o       (cc_start)
    );

    bus_capture #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CC_W   (CC_W),
        .CMD_W  (CMD_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .kind_i     (start_kind),
        .is_read_i  (is_read_i),
        .active_i   (active),
        .addr_bus_i (addr_bus_i),
        .data_i     (rd_data_i),
        .cs_addr_i  (cs_addr_i),
        .cc_i       (cc_start),
        .cc_o       (cc_in_o),
        .data_o     (data_bus_o),
        .data_oe_o  (data_bus_oe_o),
        .addr_o     (addr_bus_o),
        .addr_oe_o  (addr_bus_oe_o),
        .cmd_o      (cmd_o)
    );

endmodule

// File: rtl/io_tag_responder_chk.sv
module io_tag_responder_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_gate_i,
    input logic              svc_gate_i,
    input logic              addr_gate_ret_o,
    input logic              svc_gate_ret_o,
    input logic [CC_W-1:0]   cc_in_o,
    input logic [DATA_W-1:0] data_bus_o,
    input logic              data_bus_oe_o,
    input logic [ADDR_W-1:0] addr_bus_o,
    input logic              addr_bus_oe_o,
    input logic              cmd_strobe_o
);

    assert_rets_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_gate_ret_o && svc_gate_ret_o));

    assert_dpc_ret_needs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_gate_ret_o) |-> $past(addr_gate_i));

    assert_ret_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_gate_ret_o && addr_gate_i) |=> addr_gate_ret_o);

    assert_ret_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_gate_ret_o && !svc_gate_i) |=> !svc_gate_ret_o);

    assert_buses_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_gate_ret_o && !svc_gate_ret_o) |->
            (cc_in_o == '0 && data_bus_o == '0 && addr_bus_o == '0
             && !data_bus_oe_o && !addr_bus_oe_o));

    assert_svc_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_gate_ret_o) |-> ($past(svc_gate_i) && !$past(svc_gate_i, 2)));

    assert_addr_bus_only_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_bus_oe_o |-> svc_gate_ret_o);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_o |=> !cmd_strobe_o);

endmodule

bind io_tag_responder io_tag_responder_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CC_W   (CC_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_gate_i     (addr_gate_i),
    .svc_gate_i      (svc_gate_i),
    .addr_gate_ret_o (addr_gate_ret_o),
    .svc_gate_ret_o  (svc_gate_ret_o),
    .cc_in_o         (cc_in_o),
    .data_bus_o      (data_bus_o),
    .data_bus_oe_o   (data_bus_oe_o),
    .addr_bus_o      (addr_bus_o),
    .addr_bus_oe_o   (addr_bus_oe_o),
    .cmd_strobe_o    (cmd_strobe_o)
);

// File: tb/io_tag_responder_bench.sv
module io_tag_responder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_gate_i = 1'b0;
    logic        svc_gate_i = 1'b0;
    logic        poll_capture_i = 1'b0;
    logic [15:0] addr_bus_i = '0;
    logic        is_read_i = 1'b0;
    logic        is_cycle_steal_i = 1'b0;
    logic        ind_even_i = 1'b0;
    logic        ind_carry_i = 1'b0;
    logic        ind_overflow_i = 1'b0;
    logic [2:0]  cs_cc_i = '0;
    logic [15:0] rd_data_i = '0;
    logic [15:0] cs_addr_i = '0;
    logic        addr_gate_ret_o;
    logic        svc_gate_ret_o;
    logic [2:0]  cc_in_o;
    logic [15:0] data_bus_o;
    logic        data_bus_oe_o;
    logic [15:0] addr_bus_o;
    logic        addr_bus_oe_o;
    logic [7:0]  cmd_o;
    logic        cmd_strobe_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_tag_responder u_io_tag_responder (
        .clk(clk), .rst_n(rst_n), .addr_gate_i(addr_gate_i), .svc_gate_i(svc_gate_i),
        .poll_capture_i(poll_capture_i), .addr_bus_i(addr_bus_i), .is_read_i(is_read_i),
        .is_cycle_steal_i(is_cycle_steal_i), .ind_even_i(ind_even_i),
        .ind_carry_i(ind_carry_i), .ind_overflow_i(ind_overflow_i), .cs_cc_i(cs_cc_i),
        .rd_data_i(rd_data_i), .cs_addr_i(cs_addr_i), .addr_gate_ret_o(addr_gate_ret_o),
        .svc_gate_ret_o(svc_gate_ret_o), .cc_in_o(cc_in_o), .data_bus_o(data_bus_o),
        .data_bus_oe_o(data_bus_oe_o), .addr_bus_o(addr_bus_o),
        .addr_bus_oe_o(addr_bus_oe_o), .cmd_o(cmd_o), .cmd_strobe_o(cmd_strobe_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_quiet(input string req);
        check(req, "addr ret", {31'b0, addr_gate_ret_o}, 0);
        check(req, "svc ret", {31'b0, svc_gate_ret_o}, 0);
        check(req, "cc", {29'b0, cc_in_o}, 0);
        check(req, "data", {16'b0, data_bus_o}, 0);
        check(req, "data oe", {31'b0, data_bus_oe_o}, 0);
        check(req, "addr", {16'b0, addr_bus_o}, 0);
        check(req, "addr oe", {31'b0, addr_bus_oe_o}, 0);
    endtask

    task automatic t_reset();
        check_quiet("R1");
        check("R1", "strobe", {31'b0, cmd_strobe_o}, 0);
    endtask

    task automatic t_dpc(input bit rd);
        addr_bus_i = rd ? 16'hA53C : 16'h7E01;
        rd_data_i = 16'h1234; is_read_i = rd;
        ind_even_i = 1; ind_carry_i = 0; ind_overflow_i = 1;
        addr_gate_i = 1;
        tick();
        check("R2", "addr ret", {31'b0, addr_gate_ret_o}, 1);
        check("R2", "strobe", {31'b0, cmd_strobe_o}, 1);
        check("R2", "cmd", {24'b0, cmd_o}, rd ? 32'hA5 : 32'h7E);
        check("R5", "cc", {29'b0, cc_in_o}, 3'b101);
        check("R4", "data oe", {31'b0, data_bus_oe_o}, rd);
        check("R4", "data", {16'b0, data_bus_o}, rd ? 32'h1234 : 0);
        // change inputs mid-sequence
        addr_bus_i = 16'hFFFF; rd_data_i = 16'hBEEF; is_read_i = ~rd; ind_carry_i = 1;
        tick();
        check("R2", "strobe single", {31'b0, cmd_strobe_o}, 0);
        check("R3", "ret held", {31'b0, addr_gate_ret_o}, 1);
        check("R12", "cmd held", {24'b0, cmd_o}, rd ? 32'hA5 : 32'h7E);
        check("R12", "data held", {16'b0, data_bus_o}, rd ? 32'h1234 : 0);
        check("R12", "cc held", {29'b0, cc_in_o}, 3'b101);
        addr_gate_i = 0;
        tick();
        check_quiet("R3");
    endtask

    task automatic t_service(input bit cs);
        is_cycle_steal_i = cs; cs_cc_i = 3'b011; cs_addr_i = 16'h0C40;
        rd_data_i = 16'h5A5A; ind_even_i = 0; ind_carry_i = 1; ind_overflow_i = 1;
        poll_capture_i = 1;
        tick();
        poll_capture_i = 0;
        tick();
        check("R6", "no ret before edge", {31'b0, svc_gate_ret_o}, 0);
        svc_gate_i = 1;
        tick();
        check("R6", "svc ret", {31'b0, svc_gate_ret_o}, 1);
        check("R9", "addr oe", {31'b0, addr_bus_oe_o}, cs);
        check("R9", "addr", {16'b0, addr_bus_o}, cs ? 32'h0C40 : 0);
        check(cs ? "R9" : "R5", "cc", {29'b0, cc_in_o}, cs ? 3'b011 : 3'b110);
        check("R9", "data", {16'b0, data_bus_o}, 32'h5A5A);
        check("R9", "data oe", {31'b0, data_bus_oe_o}, 1);
        cs_addr_i = 16'h1111; is_cycle_steal_i = ~cs; rd_data_i = 0;
        tick(2);
        check("R3", "svc ret held", {31'b0, svc_gate_ret_o}, 1);
        check("R12", "addr held", {16'b0, addr_bus_o}, cs ? 32'h0C40 : 0);
        check("R12", "data held", {16'b0, data_bus_o}, 32'h5A5A);
        svc_gate_i = 0;
        tick();
        check_quiet("R3");
        // R10: second edge without new capture ignored
        svc_gate_i = 1;
        tick(2);
        check("R10", "reuse ignored", {31'b0, svc_gate_ret_o}, 0);
        svc_gate_i = 0;
        tick();
    endtask

    task automatic t_gate_high_at_capture();
        is_cycle_steal_i = 0;
        svc_gate_i = 1;
        tick(2);
        check("R8", "no capture ignored", {31'b0, svc_gate_ret_o}, 0);
        poll_capture_i = 1;
        tick();
        poll_capture_i = 0;
        tick(2);
        check("R7", "level ignored", {31'b0, svc_gate_ret_o}, 0);
        svc_gate_i = 0;
        tick();
        check("R7", "still waiting", {31'b0, svc_gate_ret_o}, 0);
        svc_gate_i = 1;
        tick();
        check("R7", "fresh edge", {31'b0, svc_gate_ret_o}, 1);
        svc_gate_i = 0;
        tick();
        check("R3", "released", {31'b0, svc_gate_ret_o}, 0);
    endtask

    task automatic t_wrong_state();
        // address gate while poll captured
        poll_capture_i = 1;
        tick();
        poll_capture_i = 0;
        addr_gate_i = 1; addr_bus_i = 16'h3300;
        tick(2);
        check("R11", "addr gate in poll", {31'b0, addr_gate_ret_o}, 0);
        check("R11", "no strobe", {31'b0, cmd_strobe_o}, 0);
        addr_gate_i = 0;
        svc_gate_i = 1;
        tick();
        check("R11", "poll still armed", {31'b0, svc_gate_ret_o}, 1);
        svc_gate_i = 0;
        tick();
        // poll capture during DPC
        addr_gate_i = 1; is_read_i = 0;
        tick();
        poll_capture_i = 1;
        tick();
        poll_capture_i = 0;
        addr_gate_i = 0;
        tick();
        svc_gate_i = 1;
        tick(2);
        check("R11", "capture in DPC ignored", {31'b0, svc_gate_ret_o}, 0);
        svc_gate_i = 0;
        tick();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        t_reset();
        rst_n = 1;
        tick();
        t_dpc(1'b1);
        t_dpc(1'b0);
        t_service(1'b1);
        t_service(1'b0);
        t_gate_high_at_capture();
        t_wrong_state();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule